// File: doc/BRIEF.md
# Parallel-Detect Link Rate Sequencer

This block chooses the line rate of a transceiver channel that can run at either 10 Gb/s or 1 Gb/s. After reset it tries the higher rate first. It watches a link-good flag from whichever PCS is active, and it filters that flag so that brief pulses are ignored. Each rate attempt has its own time limit. When an attempt runs out of time, the block asks the reconfiguration logic to retune the channel to the other rate. It then waits for an acknowledge before it starts timing the next attempt. The rates alternate in this way until a link is found.

Once the link is up, the block keeps watching it. If the link is lost, the block asks for the channel to be reinitialised at the rate it is already using, and the search starts again from that rate. A single enable input turns the automatic search on or off. When the search is off, the block still tracks and reports link state, but it never raises a request on its own.

Top module: `link_rate_seq`

## Requirements
- R1: While reset is held, `rate_is_10g` is 1, `link_up` is 0 and `rcfg_req` is 0. The first attempt after reset is made at 10G.
- R2: A 10G attempt starts at the first clock edge after reset is released, or at the edge that accepts an acknowledge. If no link comes up, `rcfg_req` rises with `rcfg_rate` = 0 (0 means 1G, 1 means 10G) exactly max(`tmo_10g`,1) clock edges after the attempt starts.
- R3: An acknowledge of a request targeting 1G sets `rate_is_10g` to 0 and starts a 1G attempt. If no link comes up, `rcfg_req` rises with `rcfg_rate` = 1 exactly max(`tmo_1g`,1) edges later. The rates keep alternating in this way.
- R4: `rcfg_req` and `rcfg_rate` stay unchanged until `rcfg_ack` is sampled high. `rate_is_10g` changes only at the edge that accepts the acknowledge. No attempt time passes while a request is pending.
- R5: Each attempt's time limit is taken from `tmo_10g` or `tmo_1g` at the edge where that attempt starts. A change to these inputs during an attempt affects only later attempts.
- R6: `link_up` rises max(`stab_len`,1)+1 edges after `pcs_link_ok` goes high and stays high. A pulse of `pcs_link_ok` shorter than max(`stab_len`,1) cycles does not set `link_up`.
- R7: While `link_up` is 1, no attempt time runs out and `rcfg_req` stays 0.
- R8: With the search enabled, `link_up` falls and `rcfg_req` rises two edges after `pcs_link_ok` drops. The request carries `rcfg_rate` equal to the current rate, and after the acknowledge the search restarts at that same rate.
- R9: With `auto_en` = 0, `rcfg_req` never rises. A timed-out attempt restarts at the same rate, and a lost link returns the block to searching without any request.
- R10: A stable link-good that arrives while a request is pending does not set `link_up`. It is taken into account one edge after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Enables automatic rate search requests |
| tmo_10g | input | CW | 10G attempt time limit in cycles (0 acts as 1) |
| tmo_1g | input | CW | 1G attempt time limit in cycles (0 acts as 1) |
| stab_len | input | SW | Cycles link-good must be stable (0 acts as 1) |
| pcs_link_ok | input | 1 | Raw link-good from the active PCS |
| rcfg_ack | input | 1 | Reconfiguration acknowledge |
| rcfg_req | output | 1 | Reconfiguration request, held until acknowledged |
| rcfg_rate | output | 1 | Requested rate: 1 = 10G, 0 = 1G |
| rate_is_10g | output | 1 | Current channel rate: 1 = 10G |
| link_up | output | 1 | Filtered, registered link state |

## Verification
The hardest case to reach from the ports is a timeout or a lost link whose request then sits unacknowledged while link-good turns stable. Reaching it needs a completed search attempt, followed by a deliberately withheld acknowledge. The bench produces this by using a short 10G limit, raising `pcs_link_ok` only after the request is visible, and holding `rcfg_ack` low for several cycles before releasing it. It then checks that the link comes up exactly one edge after the acknowledge, at the new rate. Exact timeout latencies are swept over a grid of small limits for both rates, and loss and recovery are repeated for each filter length.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [1:0] {
        ST_START  = 2'd0,
        ST_SEARCH = 2'd1,
        ST_REQ    = 2'd2,
        ST_UP     = 2'd3
    } seq_state_e;

    localparam logic RATE_10G = 1'b1;
    localparam logic RATE_1G  = 1'b0;

endpackage

// File: rtl/lrs_filter.sv
module lrs_filter #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw,
    input  logic [SW-1:0] len,
    output logic          good
);
    typedef struct packed {
        logic [SW-1:0] cnt;
        logic          good;
    } filt_t;

    filt_t q, d;
    logic [SW-1:0] lim;
    logic [SW:0]   cnt_inc;

    always_comb begin
        lim     = (len == '0) ? SW'(1) : len;
        cnt_inc = {1'b0, q.cnt} + 1'b1;
        d       = q;
        if (!raw) begin
            d.cnt  = '0;
            d.good = 1'b0;
        end else begin
            if (cnt_inc <= {1'b0, lim}) d.cnt = cnt_inc[SW-1:0];
            d.good = (cnt_inc >= {1'b0, lim});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign good = q.good;

    // R6: a low raw sample always clears the filtered flag
    p_drop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !raw |=> !good);

endmodule

// File: rtl/lrs_timer.sv
module lrs_timer #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [CW-1:0] lim_in,
    output logic          expired
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.cnt = '0;
            d.lim = (lim_in == '0) ? CW'(1) : lim_in;
        end else if (run) begin
            d.cnt = q.cnt + 1'b1;
        end else begin
            d.cnt = '0;
        end
        expired = run && (q.cnt >= q.lim - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.lim <= CW'(1);
        end else begin
            q <= d;
        end
    end

    // R2: the latched limit is never zero
    p_lim_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.lim != '0);
    // R5: a running attempt never counts past its latched limit
    p_cnt_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (q.cnt < q.lim));
    // R4: the count is held at zero while not running
    p_held_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> (q.cnt == '0));

endmodule

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
    import lrs_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          auto_en,
    input  logic          filt_good,
    input  logic          expired,
    input  logic          rcfg_ack,
    input  logic [CW-1:0] tmo_hi,
    input  logic [CW-1:0] tmo_lo,
    output logic          tmr_load,
    output logic          tmr_run,
    output logic [CW-1:0] tmr_lim,
    output logic          rcfg_req,
    output logic          rcfg_rate,
    output logic          rate_hi,
    output logic          link_up
);
    typedef struct packed {
        seq_state_e st;
        logic       rate;
        logic       req;
        logic       tgt;
        logic       up;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        unique case (q.st)
            ST_START: begin
                d.st     = ST_SEARCH;
                tmr_load = 1'b1;
            end
            ST_SEARCH: begin
                if (filt_good) begin
                    d.st = ST_UP;
                    d.up = 1'b1;
                end else if (expired) begin
                    if (auto_en) begin
                        d.st  = ST_REQ;
                        d.req = 1'b1;
                        d.tgt = ~q.rate;
                    end else begin
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_REQ: begin
                if (rcfg_ack) begin
                    d.st     = ST_SEARCH;
                    d.req    = 1'b0;
                    d.rate   = q.tgt;
                    tmr_load = 1'b1;
                end
            end
            ST_UP: begin
                if (!filt_good) begin
                    d.up = 1'b0;
                    if (auto_en) begin
                        d.st  = ST_REQ;
                        d.req = 1'b1;
                        d.tgt = q.rate;
                    end else begin
                        d.st     = ST_SEARCH;
                        tmr_load = 1'b1;
                    end
                end
            end
            default: d.st = ST_START;
        endcase
        tmr_lim = (d.rate == RATE_10G) ? tmo_hi : tmo_lo;
        tmr_run = (q.st == ST_SEARCH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_START;
            q.rate <= RATE_10G;
            q.req  <= 1'b0;
            q.tgt  <= RATE_10G;
            q.up   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rcfg_req  = q.req;
    assign rcfg_rate = q.tgt;
    assign rate_hi   = q.rate;
    assign link_up   = q.up;

    // R4: a pending request and its target hold until acknowledged
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.req && !rcfg_ack) |=> (q.req && $stable(q.tgt)));
    // R4: the channel rate moves only on an accepted acknowledge
    p_rate_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.rate) |-> $past(rcfg_ack));
    // R9: no request is raised while the search is disabled
    p_no_req_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.req) |-> $past(auto_en));
    // R7: link up and a pending request never coexist
    p_up_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.up |-> !q.req);
    // R6: link up follows the filtered flag only
    p_up_needs_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.up) |-> $past(filt_good));

endmodule

// File: rtl/link_rate_seq.sv
module link_rate_seq #(
    parameter int CW = 32,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          auto_en,
    input  logic [CW-1:0] tmo_10g,
    input  logic [CW-1:0] tmo_1g,
    input  logic [SW-1:0] stab_len,
    input  logic          pcs_link_ok,
    input  logic          rcfg_ack,
    output logic          rcfg_req,
    output logic          rcfg_rate,
    output logic          rate_is_10g,
    output logic          link_up
);
    logic          filt_good;
    logic          expired;
    logic          tmr_load;
    logic          tmr_run;
    logic [CW-1:0] tmr_lim;

    lrs_filter #(.SW(SW)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pcs_link_ok),
        .len  (stab_len),
        .good (filt_good)
    );

    lrs_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .run    (tmr_run),
        .lim_in (tmr_lim),
        .expired(expired)
    );

    lrs_ctrl #(.CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (auto_en),
        .filt_good(filt_good),
        .expired  (expired),
        .rcfg_ack (rcfg_ack),
        .tmo_hi   (tmo_10g),
        .tmo_lo   (tmo_1g),
        .tmr_load (tmr_load),
        .tmr_run  (tmr_run),
        .tmr_lim  (tmr_lim),
        .rcfg_req (rcfg_req),
        .rcfg_rate(rcfg_rate),
        .rate_hi  (rate_is_10g),
        .link_up  (link_up)
    );

endmodule

// File: tb/sim_link_rate_seq.sv
module sim_link_rate_seq;
    localparam int CW = 32;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          auto_en = 1'b1;
    logic [CW-1:0] tmo_10g = 32'd10;
    logic [CW-1:0] tmo_1g = 32'd10;
    logic [SW-1:0] stab_len = 8'd1;
    logic          pcs_link_ok = 1'b0;
    logic          rcfg_ack = 1'b0;
    logic          rcfg_req, rcfg_rate, rate_is_10g, link_up;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    link_rate_seq #(.CW(CW), .SW(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .tmo_10g(tmo_10g),
        .tmo_1g(tmo_1g), .stab_len(stab_len), .pcs_link_ok(pcs_link_ok),
        .rcfg_ack(rcfg_ack), .rcfg_req(rcfg_req), .rcfg_rate(rcfg_rate),
        .rate_is_10g(rate_is_10g), .link_up(link_up)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int th, input int tl, input int st, input bit ae);
        @(negedge clk);
        rst_n = 1'b0; tmo_10g = th; tmo_1g = tl; stab_len = st[SW-1:0];
        auto_en = ae; pcs_link_ok = 1'b0; rcfg_ack = 1'b0;
        repeat (3) @(negedge clk);
        check(rate_is_10g == 1'b1 && link_up == 1'b0 && rcfg_req == 1'b0,
              "R1 reset outputs", {rate_is_10g, link_up, rcfg_req}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_req(output int k);
        k = 0;
        while (!rcfg_req && k < 2000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic give_ack();
        rcfg_ack = 1'b1;
        @(negedge clk);
        rcfg_ack = 1'b0;
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    initial begin : watchdog
        int cyc;
        cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int k;
        // R2 R3 R4: sweep both attempt limits
        foreach (int_th_dummy[i]) ;
        for (int th = 0; th <= 5; th++) begin
            for (int tl = 0; tl <= 4; tl++) begin
                do_reset(th, tl, 1, 1'b1);
                wait_req(k);
                check(k == eff(th) && rcfg_rate == 1'b0, "R2 10G timeout", k, eff(th));
                repeat (3) @(negedge clk);
                check(rcfg_req && rcfg_rate == 1'b0 && rate_is_10g, "R4 request held", rcfg_req, 1);
                give_ack();
                check(rate_is_10g == 1'b0 && !rcfg_req, "R3 switched to 1G", rate_is_10g, 0);
                wait_req(k);
                check(k == eff(tl) && rcfg_rate == 1'b1, "R3 1G timeout", k, eff(tl));
                give_ack();
                check(rate_is_10g == 1'b1, "R3 back to 10G", rate_is_10g, 1);
                wait_req(k);
                check(k == eff(th) && rcfg_rate == 1'b0, "R2 alternation", k, eff(th));
            end
        end

        // R5: limit sampled at attempt start
        do_reset(6, 3, 1, 1'b1);
        tmo_10g = 2;
        wait_req(k);
        check(k == 6, "R5 current attempt keeps limit", k, 6);
        give_ack();
        wait_req(k);
        check(k == 3, "R5 1G attempt", k, 3);
        give_ack();
        wait_req(k);
        check(k == 2, "R5 next attempt uses new limit", k, 2);

        // R6 R7 R8: filter lengths, link hold and loss
        for (int s = 0; s <= 4; s++) begin
            do_reset(200, 200, s, 1'b1);
            if (eff(s) > 1) begin
                pcs_link_ok = 1'b1;
                repeat (eff(s) - 1) @(negedge clk);
                pcs_link_ok = 1'b0;
                repeat (eff(s) + 3) @(negedge clk);
                check(!link_up, "R6 short pulse ignored", link_up, 0);
            end
            pcs_link_ok = 1'b1;
            k = 0;
            while (!link_up && k < 50) begin
                @(negedge clk);
                k++;
            end
            check(k == eff(s) + 1, "R6 link up latency", k, eff(s) + 1);
            begin
                int bad;
                bad = 0;
                for (int c = 0; c < 250; c++) begin
                    @(negedge clk);
                    if (!link_up || rcfg_req) bad++;
                end
                check(bad == 0, "R7 link held without request", bad, 0);
            end
            pcs_link_ok = 1'b0;
            @(negedge clk);
            check(link_up && !rcfg_req, "R8 one edge after loss", link_up, 1);
            @(negedge clk);
            check(!link_up && rcfg_req && rcfg_rate == 1'b1, "R8 loss request same rate",
                  {link_up, rcfg_req, rcfg_rate}, 3'b011);
            give_ack();
            check(rate_is_10g == 1'b1, "R8 rate kept", rate_is_10g, 1);
            wait_req(k);
            check(k == 200 && rcfg_rate == 1'b0, "R8 search restarted", k, 200);
        end

        // R10: stable link during pending request
        do_reset(3, 50, 1, 1'b1);
        wait_req(k);
        pcs_link_ok = 1'b1;
        repeat (5) @(negedge clk);
        check(!link_up && rcfg_req, "R10 ignored while pending", link_up, 0);
        give_ack();
        check(!link_up, "R10 not yet up at ack", link_up, 0);
        @(negedge clk);
        check(link_up && rate_is_10g == 1'b0, "R10 up one edge after ack",
              {link_up, rate_is_10g}, 2'b10);

        // R9: search disabled
        do_reset(3, 3, 1, 1'b0);
        begin
            int reqs;
            reqs = 0;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (rcfg_req) reqs++;
            end
            check(reqs == 0 && rate_is_10g, "R9 no request on timeout", reqs, 0);
            pcs_link_ok = 1'b1;
            repeat (2) @(negedge clk);
            check(link_up, "R9 link still tracked", link_up, 1);
            pcs_link_ok = 1'b0;
            repeat (2) @(negedge clk);
            check(!link_up && !rcfg_req, "R9 loss without request", {link_up, rcfg_req}, 0);
            reqs = 0;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (rcfg_req) reqs++;
            end
            check(reqs == 0 && rate_is_10g, "R9 quiet after loss", reqs, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    int int_th_dummy[1];

endmodule